// File: doc/BRIEF.md
# Ethernet Transmit Outcome Tracker

This block follows one Ethernet transmit attempt at a time and turns the events reported by the MAC transmit path into a 32-bit read-only outcome word. An attempt is opened by a start pulse. The destination address is sampled at that pulse and classified as broadcast, multicast or unicast. While the attempt is open, the block counts nibble times spent deferring, nibble times since the last (re)start of transmission, and the normal collisions seen so far. The attempt then ends in one of two ways: the MAC reports the frame as done, or one of four abort causes fires.

The four abort causes are a FIFO underrun, a late collision, too many collisions, and excessive deferral. Any abort freezes the transmit engine: the halt output rises and further start pulses are refused. A sticky transmit-error interrupt flag is raised at the same time. Both stay set until software pulses the clear input. The outcome word is cleared again when the next accepted attempt begins.

The deferral limit depends on the line rate. It is 6071 nibble times at 100 Mbps and 24,287 at 10 Mbps. A configuration input can turn the deferral abort off.

Top module: `eth_tx_outcome`

## Requirements
- R1: After a synchronous reset, `status` is 0 and `busy`, `halt` and `tx_err_irq` are all 0.
- R2: A `frm_start` pulse is accepted only when `busy` and `halt` are both 0. One cycle later `busy` is 1 and `status` reads 0. A `frm_start` while busy is ignored, and it does not change the address class already captured.
- R3: `dest_addr[47:40]` is the first octet. An all-ones address gives class broadcast (`status[14]`). Otherwise, `dest_addr[40]` set gives class multicast (`status[13]`). The class is captured at an accepted start and written when the attempt ends, and bits 14 and 13 are never both set.
- R4: `frm_done` during an open attempt with no abort sets `status[15]` together with the class bits, and `busy` returns to 0.
- R5: The position count is the number of `nib_tick` pulses seen while not deferring since the start or the last collision. A collision with a position count above `coll_win` aborts with `status[12]`.
- R6: A collision with a position count at or below `coll_win` is normal: it adds one to the retry count and restarts the position count. A normal collision arriving when the retry count already equals `retry_lim` aborts with `status[10]`.
- R7: A `nib_tick` with `defer_act` high adds one deferral nibble, and the count is kept across the whole attempt. With `xdefer_ok` = 0, the deferral tick that would take the count above 6071 (`rate_100`=1) or 24287 (`rate_100`=0) aborts with `status[11]`. With `xdefer_ok` = 1 there is no deferral abort.
- R8: `fifo_urun` during an open attempt aborts with `status[9]`.
- R9: An abort ends the attempt. It writes exactly one cause bit plus the class bits, and `status[15]` stays 0. When several causes occur in one cycle, the order of precedence is underrun, then late collision, then excessive collisions, then deferral. An abort takes precedence over a `frm_done` in the same cycle.
- R10: An abort sets `halt` and `tx_err_irq`. Both hold until a `sw_clr` pulse, which leaves `status` untouched. A `sw_clr` in the same cycle as an abort leaves both set.
- R11: `status[31:16]` and `status[8:0]` always read 0.
- R12: Collision, underrun, done and deferral events arriving while `busy` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | Open a transmit attempt |
| dest_addr | input | 48 | Destination address, first octet in [47:40] |
| nib_tick | input | 1 | One nibble time elapsed |
| defer_act | input | 1 | Transmitter is deferring this nibble |
| coll_evt | input | 1 | Collision seen |
| fifo_urun | input | 1 | Transmit FIFO underran |
| frm_done | input | 1 | MAC finished sending the frame |
| rate_100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| coll_win | input | 10 | Collision window in nibble times |
| retry_lim | input | 4 | Normal collisions allowed per frame |
| xdefer_ok | input | 1 | 1 disables the excessive-deferral abort |
| sw_clr | input | 1 | Clears halt and the error flag |
| status | output | 32 | Outcome word |
| busy | output | 1 | Attempt open |
| halt | output | 1 | Transmit engine halted after an abort |
| tx_err_irq | output | 1 | Sticky transmit-error flag |

## Verification
The bench targets the exact deferral boundaries at both rates. A limit that is off by one would abort one tick early, or keep going one tick past the limit. It places a collision exactly at the window edge, where a wrong comparison would report a late collision in place of a retry. It counts retries up to the limit, where an off-by-one would allow a collision too many or too few. It fires several causes together with `frm_done` and `sw_clr` in the same cycle: a wrong precedence would show two cause bits, report success, or drop the halt. It also drives events while idle and starts while busy or halted. A design that does not gate these would corrupt the class or reopen a halted engine.

// File: rtl/eth_txo_pkg.sv
package eth_txo_pkg;
  localparam int DEFER_LIM_FAST = 6071;
  localparam int DEFER_LIM_SLOW = 24287;

  typedef enum logic [1:0] {
    CLS_UNI   = 2'd0,
    CLS_MULTI = 2'd1,
    CLS_BCAST = 2'd2
  } addr_cls_e;

  typedef struct packed {
    logic [15:0] rsvd_hi;
    logic        ok;
    logic        bcast;
    logic        mcast;
    logic        late;
    logic        xdef;
    logic        xcol;
    logic        urun;
    logic [8:0]  rsvd_lo;
  } txo_status_t;
endpackage

// File: rtl/eth_txo_addr_class.sv
module eth_txo_addr_class
  import eth_txo_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic [ADDR_W-1:0] addr,
  output addr_cls_e         cls
);
  localparam int FIRST_LSB = ADDR_W - 8;

  always_comb begin
    if (&addr)                cls = CLS_BCAST;
    else if (addr[FIRST_LSB]) cls = CLS_MULTI;
    else                      cls = CLS_UNI;
  end
endmodule

// File: rtl/eth_txo_defer.sv
module eth_txo_defer
  import eth_txo_pkg::*;
#(
  parameter int LIM_FAST = DEFER_LIM_FAST,
  parameter int LIM_SLOW = DEFER_LIM_SLOW
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic nib_tick,
  input  logic defer_act,
  input  logic rate_100,
  input  logic xdefer_ok,
  output logic over
);
  localparam int LIM_MAX = (LIM_FAST > LIM_SLOW) ? LIM_FAST : LIM_SLOW;
  localparam int CNT_W   = $clog2(LIM_MAX + 2);

  logic [CNT_W-1:0] dcnt;
  logic [CNT_W-1:0] lim;
  logic             dtick;

  assign lim   = rate_100 ? CNT_W'(LIM_FAST) : CNT_W'(LIM_SLOW);
  assign dtick = en && nib_tick && defer_act;
  assign over  = dtick && !xdefer_ok && (dcnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || clr)                dcnt <= '0;
    else if (dtick && dcnt < lim)  dcnt <= dcnt + 1'b1;
  end

  AST_DEFER_BOUND: assert property (@(posedge clk) disable iff (rst)
    dcnt <= CNT_W'(LIM_MAX)); // R7
endmodule

// File: rtl/eth_txo_coll.sv
module eth_txo_coll #(
  parameter int WIN_W   = 10,
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               en,
  input  logic               nib_tick,
  input  logic               defer_act,
  input  logic               coll_evt,
  input  logic [WIN_W-1:0]   coll_win,
  input  logic [RETRY_W-1:0] retry_lim,
  output logic               late,
  output logic               excess
);
  localparam int POS_W = WIN_W + 1;

  logic [POS_W-1:0]   pos;
  logic [RETRY_W-1:0] ccnt;
  logic               hit, normal;

  assign hit    = en && coll_evt;
  assign late   = hit && (pos > POS_W'(coll_win));
  assign normal = hit && !late;
  assign excess = normal && (ccnt >= retry_lim);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pos  <= '0;
      ccnt <= '0;
    end else begin
      if (hit)
        pos <= '0;
      else if (en && nib_tick && !defer_act && !(&pos))
        pos <= pos + 1'b1;
      if (normal && !excess)
        ccnt <= ccnt + 1'b1;
    end
  end

  AST_LATE_XOR_EXCESS: assert property (@(posedge clk) disable iff (rst)
    !(late && excess)); // R6
endmodule

// File: rtl/eth_tx_outcome.sv
module eth_tx_outcome
  import eth_txo_pkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int WIN_W    = 10,
  parameter int RETRY_W  = 4,
  parameter int LIM_FAST = DEFER_LIM_FAST,
  parameter int LIM_SLOW = DEFER_LIM_SLOW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frm_start,
  input  logic [ADDR_W-1:0]  dest_addr,
  input  logic               nib_tick,
  input  logic               defer_act,
  input  logic               coll_evt,
  input  logic               fifo_urun,
  input  logic               frm_done,
  input  logic               rate_100,
  input  logic [WIN_W-1:0]   coll_win,
  input  logic [RETRY_W-1:0] retry_lim,
  input  logic               xdefer_ok,
  input  logic               sw_clr,
  output logic [31:0]        status,
  output logic               busy,
  output logic               halt,
  output logic               tx_err_irq
);
  addr_cls_e   cls_now, cls_q;
  txo_status_t st_q;
  logic        start_acc, c_late, c_xcol, c_xdef;
  logic        a_urun, a_late, a_xcol, a_xdef, abort, done_ok;

  assign start_acc = frm_start && !busy && !halt;

  eth_txo_addr_class #(.ADDR_W(ADDR_W)) u_cls (
    .addr (dest_addr),
    .cls  (cls_now)
  );

  eth_txo_defer #(.LIM_FAST(LIM_FAST), .LIM_SLOW(LIM_SLOW)) u_defer (
    .clk       (clk),
    .rst       (rst),
    .clr       (start_acc),
    .en        (busy),
    .nib_tick  (nib_tick),
    .defer_act (defer_act),
    .rate_100  (rate_100),
    .xdefer_ok (xdefer_ok),
    .over      (c_xdef)
  );

  eth_txo_coll #(.WIN_W(WIN_W), .RETRY_W(RETRY_W)) u_coll (
    .clk       (clk),
    .rst       (rst),
    .clr       (start_acc),
    .en        (busy),
    .nib_tick  (nib_tick),
    .defer_act (defer_act),
    .coll_evt  (coll_evt),
    .coll_win  (coll_win),
    .retry_lim (retry_lim),
    .late      (c_late),
    .excess    (c_xcol)
  );

  // precedence: underrun, late, excessive collisions, deferral
  always_comb begin
    a_urun = busy && fifo_urun;
    a_late = !a_urun && c_late;
    a_xcol = !a_urun && !a_late && c_xcol;
    a_xdef = !a_urun && !a_late && !a_xcol && c_xdef;
  end

  assign abort   = a_urun || a_late || a_xcol || a_xdef;
  assign done_ok = busy && frm_done && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      cls_q <= CLS_UNI;
      busy  <= 1'b0;
    end else if (start_acc) begin
      st_q  <= '0;
      cls_q <= cls_now;
      busy  <= 1'b1;
    end else if (abort || done_ok) begin
      busy       <= 1'b0;
      st_q.ok    <= done_ok;
      st_q.bcast <= (cls_q == CLS_BCAST);
      st_q.mcast <= (cls_q == CLS_MULTI);
      st_q.urun  <= a_urun;
      st_q.late  <= a_late;
      st_q.xcol  <= a_xcol;
      st_q.xdef  <= a_xdef;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt       <= 1'b0;
      tx_err_irq <= 1'b0;
    end else if (abort) begin
      halt       <= 1'b1;
      tx_err_irq <= 1'b1;
    end else if (sw_clr) begin
      halt       <= 1'b0;
      tx_err_irq <= 1'b0;
    end
  end

  assign status = st_q;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    status[31:16] == 16'h0 && status[8:0] == 9'h0); // R11
  AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(status[14] && status[13])); // R3
  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(status[12:9])); // R9
  AST_OK_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
    status[15] |-> status[12:9] == 4'h0); // R9
  AST_ABORT_HALTS: assert property (@(posedge clk) disable iff (rst)
    abort |=> halt && tx_err_irq && !busy); // R10
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    halt && !sw_clr |=> halt); // R10
  AST_HALT_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
    halt && frm_start |=> !busy); // R2
endmodule

// File: tb/eth_tx_outcome_test.sv
module eth_tx_outcome_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        frm_start = 0, nib_tick = 0, defer_act = 0, coll_evt = 0;
  logic        fifo_urun = 0, frm_done = 0, rate_100 = 1, xdefer_ok = 0, sw_clr = 0;
  logic [47:0] dest_addr = '0;
  logic [9:0]  coll_win = 10'd5;
  logic [3:0]  retry_lim = 4'd3;
  logic [31:0] status;
  logic        busy, halt, tx_err_irq;

  int checks = 0, fails = 0;
  bit done_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_tx_outcome uut (
    .clk(clk), .rst(rst), .frm_start(frm_start), .dest_addr(dest_addr),
    .nib_tick(nib_tick), .defer_act(defer_act), .coll_evt(coll_evt),
    .fifo_urun(fifo_urun), .frm_done(frm_done), .rate_100(rate_100),
    .coll_win(coll_win), .retry_lim(retry_lim), .xdefer_ok(xdefer_ok),
    .sw_clr(sw_clr), .status(status), .busy(busy), .halt(halt),
    .tx_err_irq(tx_err_irq)
  );

  // behavioural reference model
  bit [31:0] m_st;
  bit        m_busy, m_halt, m_irq;
  int        m_cls, m_def, m_pos, m_ret;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_busy = 0; m_halt = 0; m_irq = 0;
      m_cls = 0; m_def = 0; m_pos = 0; m_ret = 0;
    end else begin
      int lim, cause;
      bit dtk, col_late, col_norm;
      lim = rate_100 ? 6071 : 24287;
      cause = -1;
      dtk = m_busy && nib_tick && defer_act;
      col_late = m_busy && coll_evt && (m_pos > coll_win);
      col_norm = m_busy && coll_evt && !col_late;
      if (m_busy && fifo_urun) cause = 9;
      else if (col_late) cause = 12;
      else if (col_norm && m_ret >= retry_lim) cause = 10;
      else if (dtk && !xdefer_ok && m_def >= lim) cause = 11;
      if (frm_start && !m_busy && !m_halt) begin
        m_busy = 1; m_st = 0; m_def = 0; m_pos = 0; m_ret = 0;
        m_cls = (dest_addr == {48{1'b1}}) ? 14 : (dest_addr[40] ? 13 : 0);
      end else begin
        if (m_busy && (cause >= 0 || frm_done)) begin
          m_st = 0;
          if (m_cls != 0) m_st[m_cls] = 1;
          if (cause >= 0) m_st[cause] = 1; else m_st[15] = 1;
          m_busy = 0;
        end else if (m_busy) begin
          if (dtk && m_def < lim) m_def++;
          if (coll_evt) m_pos = 0;
          else if (nib_tick && !defer_act && m_pos < 2047) m_pos++;
          if (col_norm) m_ret++;
        end
      end
      if (cause >= 0) begin m_halt = 1; m_irq = 1; end
      else if (sw_clr) begin m_halt = 0; m_irq = 0; end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) if (!rst && !done_run) begin
    chk("R4 ok bit",     status[15],    m_st[15]);
    chk("R3 class",      status[14:13], m_st[14:13]);
    chk("R5 late",       status[12],    m_st[12]);
    chk("R7 deferral",   status[11],    m_st[11]);
    chk("R6 retries",    status[10],    m_st[10]);
    chk("R8 underrun",   status[9],     m_st[9]);
    chk("R11 reserved",  {status[31:16], status[8:0]}, '0);
    chk("R2 busy",       busy,          m_busy);
    chk("R10 halt",      halt,          m_halt);
    chk("R10 irq",       tx_err_irq,    m_irq);
  end

  task automatic go(); @(negedge clk); endtask
  task automatic start(logic [47:0] a);
    dest_addr = a; frm_start = 1; go(); frm_start = 0;
  endtask
  task automatic ticks(int n, bit d);
    nib_tick = 1; defer_act = d;
    for (int i = 0; i < n; i++) go();
    nib_tick = 0; defer_act = 0;
  endtask
  task automatic coll(); coll_evt = 1; go(); coll_evt = 0; endtask
  task automatic done(); frm_done = 1; go(); frm_done = 0; endtask
  task automatic urun(); fifo_urun = 1; go(); fifo_urun = 0; endtask
  task automatic clear(); sw_clr = 1; go(); sw_clr = 0; endtask

  localparam logic [47:0] BC = {48{1'b1}};
  localparam logic [47:0] MC = 48'h0100_0000_0000;
  localparam logic [47:0] UC = 48'h0200_0000_0001;

  initial begin
    repeat (3) go();
    chk("R1 status", status, 0); chk("R1 busy", busy, 0);
    chk("R1 halt", halt, 0);     chk("R1 irq", tx_err_irq, 0);
    rst = 0; go();

    start(BC); chk("R2 busy after start", busy, 1); chk("R2 status cleared", status, 0);
    ticks(3, 0); done(); chk("R4 bcast ok", status, 32'h0000_C000); chk("R4 idle", busy, 0);
    start(MC); done(); chk("R3 multicast", status, 32'h0000_A000);
    start(UC); done(); chk("R3 unicast", status, 32'h0000_8000);

    start(UC); start(BC); done(); chk("R2 start while busy ignored", status, 32'h0000_8000);

    coll(); urun(); done(); ticks(2, 1);
    chk("R12 idle events status", status, 32'h0000_8000); chk("R12 idle no halt", halt, 0);

    start(UC); ticks(5, 0); coll(); chk("R6 collision at window", busy, 1);
    ticks(2, 0); done(); chk("R6 completes after retry", status, 32'h0000_8000);

    start(MC); ticks(6, 0); coll();
    chk("R5 late collision", status, 32'h0000_3000);
    chk("R10 halt on abort", halt, 1); chk("R10 irq on abort", tx_err_irq, 1);
    chk("R9 abort ends attempt", busy, 0);
    start(UC); chk("R10 start refused while halted", busy, 0);
    go(); chk("R10 halt persists", halt, 1);
    clear(); chk("R10 cleared halt", halt, 0); chk("R10 cleared irq", tx_err_irq, 0);
    chk("R10 status kept", status, 32'h0000_3000);

    retry_lim = 4'd2; start(UC);
    ticks(1, 0); coll(); ticks(1, 0); coll(); chk("R6 two retries allowed", busy, 1);
    ticks(1, 0); coll(); chk("R6 excessive collisions", status, 32'h0000_0400);
    clear();

    rate_100 = 1; start(UC); ticks(6071, 1); chk("R7 fast at limit", busy, 1);
    ticks(1, 1); chk("R7 fast over limit", status, 32'h0000_0800); clear();
    rate_100 = 0; start(UC); ticks(24287, 1); chk("R7 slow at limit", busy, 1);
    ticks(1, 1); chk("R7 slow over limit", status, 32'h0000_0800); clear();
    xdefer_ok = 1; start(UC); ticks(25000, 1); chk("R7 abort disabled", busy, 1);
    done(); chk("R7 completes", status, 32'h0000_8000); xdefer_ok = 0;

    start(BC); urun(); chk("R8 underrun", status, 32'h0000_4200); clear();

    start(UC); ticks(6, 0);
    coll_evt = 1; fifo_urun = 1; frm_done = 1; go();
    coll_evt = 0; fifo_urun = 0; frm_done = 0;
    chk("R9 precedence and abort beats done", status, 32'h0000_0200); clear();

    start(UC); fifo_urun = 1; sw_clr = 1; go(); fifo_urun = 0; sw_clr = 0;
    chk("R10 clear loses to abort", halt, 1); chk("R10 irq kept", tx_err_irq, 1);
    clear(); go();

    done_run = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_run) begin
      done_run = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule